// File: doc/BRIEF.md
# DMA Global Control and Status Registers

This block holds the shared registers of an eight-channel DMA controller. Software selects each channel's transfer mode (disabled, scatter-gather or one-shot) and direction through one packed control word. The block drives those settings straight to the channel engines. Each engine reports back a completion pulse, an error pulse and a live two-bit activity state.

Completions and errors are latched into a combined status word. Software acknowledges them by writing ones, and the usual way is to write back the value it just read. A per-channel enable mask gates the latched completions onto one level-sensitive interrupt line.

Access is through a simple word-wide register port. Reads are combinational on the address. A write takes effect at the clock edge on which `wr_en` is high.

Top module: `dma_regfile`

## Requirements
- R1: After reset the control, enable and latched status bits are all zero, `irq` is low, and every channel sees mode 0 with direction 0.
- R2: The control word sits at byte offset 0x00. Channel n owns bits 4n+3:4n: mode in bits 4n+1:4n and direction in bit 4n+2. Bit 4n+3 always reads 0, and writes to it are ignored.
- R3: Mode codes are 0 = disabled, 1 = scatter-gather and 2 = one-shot. These drive `ch_mode` unchanged. Code 3 is undefined: it reads back as written but drives `ch_mode` with 0. `ch_dir[n]` follows bit 4n+2.
- R4: The interrupt-enable word sits at byte offset 0x08. Bits 7:0 enable channels 0..7. Bits 31:8 read 0, and writes to them are ignored.
- R5: A `ch_done[n]` pulse sampled at a clock edge sets pending bit n of the status word (byte offset 0x10) after that edge.
- R6: A `ch_err[n]` pulse sets error bit n+8 and pending bit n of the status word at the same edge.
- R7: A status write clears every pending bit or error bit where `wdata` holds a one. Zero bits leave the flags unchanged. Writing back a value just read clears exactly the flags that were set.
- R8: When a completion or error sets a flag on the same edge that a status write clears it, the flag stays set.
- R9: Status bits 16+2n+1:16+2n show `ch_state` for channel n live. Writes to them are ignored.
- R10: `irq` is high exactly when some pending bit and its enable bit are both set. It follows the registers, so it changes after the edge that updates them.
- R11: Reads of any other offset, including misaligned offsets, return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ch_mode | output | 2*NCH | Per-channel mode, two bits each |
| ch_dir | output | NCH | Per-channel direction |
| ch_done | input | NCH | Per-channel completion pulse |
| ch_err | input | NCH | Per-channel error pulse |
| ch_state | input | 2*NCH | Per-channel activity state, two bits each |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can collide in one cycle: a hardware event setting a status flag, and a software write-one-to-clear of the same flag. The bench provokes this by asserting `ch_done` or `ch_err` during the very cycle in which a status write clears that channel's bit. It then reads the status word on the following cycle. The flag is judged correct only if it survives, while the clearing of a flag with no competing event is checked separately.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 8,
  parameter int AW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [2*NCH-1:0] ch_mode,
  output logic [NCH-1:0]   ch_dir,
  input  logic [NCH-1:0]   ch_done,
  input  logic [NCH-1:0]   ch_err,
  input  logic [2*NCH-1:0] ch_state,
  output logic             irq
);

  localparam logic [AW-1:0] OFS_CTRL = AW'(0);
  localparam logic [AW-1:0] OFS_IEN  = AW'(8);
  localparam logic [AW-1:0] OFS_STAT = AW'(16);

  function automatic logic [4*NCH-1:0] ctrl_mask();
    logic [4*NCH-1:0] m;
    m = '0;
    for (int i = 0; i < NCH; i++) m[4*i +: 4] = 4'b0111;
    return m;
  endfunction

  localparam logic [4*NCH-1:0] CTRL_WM = ctrl_mask();

  logic [4*NCH-1:0] ctrl_q;
  logic [NCH-1:0]   ien_q, pend_q, errf_q;

  wire wr_ctrl = wr_en && (addr == OFS_CTRL);
  wire wr_ien  = wr_en && (addr == OFS_IEN);
  wire wr_stat = wr_en && (addr == OFS_STAT);

  wire [NCH-1:0] clr_p = wr_stat ? wdata[NCH-1:0]   : '0;
  wire [NCH-1:0] clr_e = wr_stat ? wdata[8 +: NCH]  : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      pend_q <= '0;
      errf_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[4*NCH-1:0] & CTRL_WM;
      if (wr_ien)  ien_q  <= wdata[NCH-1:0];
      pend_q <= (pend_q & ~clr_p) | ch_done | ch_err;
      errf_q <= (errf_q & ~clr_e) | ch_err;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    wire [1:0] fld = ctrl_q[4*n +: 2];
    assign ch_mode[2*n +: 2] = (fld == 2'b11) ? 2'b00 : fld;
    assign ch_dir[n]         = ctrl_q[4*n+2];
  end

  assign irq = |(pend_q & ien_q);

  always_comb begin
    rdata = '0;
    if (addr == OFS_CTRL) begin
      rdata[4*NCH-1:0] = ctrl_q;
    end else if (addr == OFS_IEN) begin
      rdata[NCH-1:0] = ien_q;
    end else if (addr == OFS_STAT) begin
      rdata[NCH-1:0]      = pend_q;
      rdata[8 +: NCH]     = errf_q;
      rdata[16 +: 2*NCH]  = ch_state;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!irq && ch_mode == '0 && ch_dir == '0)); // R1

  AST_ERR_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_err != '0) |=> (((pend_q & errf_q) & $past(ch_err)) == $past(ch_err))); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done != '0) |=> ((pend_q & $past(ch_done)) == $past(ch_done))); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((pend_q & $past(wdata[NCH-1:0]) & ~$past(ch_done | ch_err)) == '0)); // R7

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && ch_done == '0 && ch_err == '0) |=> ($stable(pend_q) && $stable(errf_q))); // R7

  AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R10

endmodule

// File: tb/dma_regfile_tb.sv
`timescale 1ns/1ps
module dma_regfile_tb;
  localparam int NCH = 8;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] ch_mode, ch_state = '0;
  logic [7:0]  ch_dir, ch_done = '0, ch_err = '0;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  dma_regfile #(.NCH(NCH), .AW(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_mode(ch_mode), .ch_dir(ch_dir), .ch_done(ch_done),
    .ch_err(ch_err), .ch_state(ch_state), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(logic [7:0] dn, logic [7:0] er);
    @(negedge clk); ch_done = dn; ch_err = er;
    @(negedge clk); ch_done = '0; ch_err = '0;
  endtask

  task automatic clash(logic [7:0] dn, logic [7:0] er, logic [31:0] d);
    @(negedge clk); ch_done = dn; ch_err = er; wr_en = 1; addr = 5'h10; wdata = d;
    @(negedge clk); ch_done = '0; ch_err = '0; wr_en = 0; wdata = '0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'h00, v); chk("R1 ctrl", v, 0);
    rd(5'h08, v); chk("R1 ien", v, 0);
    rd(5'h10, v); chk("R1 stat", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mode", 32'(ch_mode), 0);
    chk("R1 dir", 32'(ch_dir), 0);

    // R2 R3 sweep every nibble on every channel
    for (int c = 0; c < NCH; c++) begin
      for (int nib = 0; nib < 16; nib++) begin
        logic [1:0] m;
        wr(5'h00, 32'(nib) << (4*c));
        rd(5'h00, v); chk("R2 ctrl readback", v, 32'(nib & 7) << (4*c));
        m = 2'(nib & 3);
        if (m == 2'd3) m = 2'd0;
        chk("R3 mode out", 32'(ch_mode), 32'(m) << (2*c));
        chk("R3 dir out", 32'(ch_dir), 32'((nib >> 2) & 1) << c);
      end
    end
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); chk("R2 all fields", v, 32'h7777_7777);
    chk("R3 mode 3 disabled", 32'(ch_mode), 0);
    chk("R3 dir all", 32'(ch_dir), 32'hFF);
    wr(5'h00, 32'h0000_0000);

    // R4 enable reserved bits
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R4 ien", v, 32'hFF);
    wr(5'h08, 0);

    // R5 R6 R7 R8 R10 per channel
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] b;
      b = 8'(1 << c);
      pulse(b, 0);
      rd(5'h10, v); chk("R5 pend", v, 32'(b));
      chk("R10 irq masked", 32'(irq), 0);
      wr(5'h08, 32'(b));       chk("R10 irq enabled", 32'(irq), 1);
      wr(5'h08, 32'(~b));      chk("R10 other enables", 32'(irq), 0);
      wr(5'h08, 32'hFF);       chk("R10 all enables", 32'(irq), 1);
      wr(5'h10, 0);
      rd(5'h10, v); chk("R7 zero write no effect", v, 32'(b));
      wr(5'h10, v);
      rd(5'h10, v); chk("R7 write back clears", v, 0);
      chk("R10 irq drops", 32'(irq), 0);

      pulse(0, b);
      rd(5'h10, v); chk("R6 err and pend", v, 32'(b) | (32'(b) << 8));
      chk("R10 irq on err", 32'(irq), 1);
      wr(5'h10, 32'(b));
      rd(5'h10, v); chk("R7 pend only cleared", v, 32'(b) << 8);
      wr(5'h10, 32'(b) << 8);
      rd(5'h10, v); chk("R7 err cleared", v, 0);

      pulse(b, 0);
      clash(b, 0, 32'(b));
      rd(5'h10, v); chk("R8 done beats clear", v, 32'(b));
      pulse(0, b);
      clash(0, b, (32'(b) << 8) | 32'(b));
      rd(5'h10, v); chk("R8 err beats clear", v, 32'(b) | (32'(b) << 8));
      wr(5'h10, 32'hFFFF);
      rd(5'h10, v); chk("R7 final clear", v, 0);
      wr(5'h08, 0);
    end

    // multi-channel pattern
    pulse(8'hA5, 0);
    rd(5'h10, v); chk("R5 multi pend", v, 32'hA5);
    wr(5'h08, 32'h5A); chk("R10 disjoint masks", 32'(irq), 0);
    wr(5'h08, 32'h01); chk("R10 overlap", 32'(irq), 1);
    wr(5'h10, 32'hA5); wr(5'h08, 0);

    // R9 state passthrough and read-only
    for (int p = 0; p < 12; p++) begin
      logic [15:0] s;
      s = (p < 8) ? 16'(3 << (2*p)) : (p == 8 ? 16'hFFFF : p == 9 ? 16'h1B6C : p == 10 ? 16'hE4E4 : 16'h0000);
      ch_state = s;
      rd(5'h10, v); chk("R9 state live", v, 32'(s) << 16);
      wr(5'h10, 32'hFFFF_0000);
      rd(5'h10, v); chk("R9 state write ignored", v, 32'(s) << 16);
    end
    ch_state = '0;

    // R11 unmapped and misaligned
    wr(5'h00, 32'h1234_5672);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    wr(5'h09, 32'hFFFF_FFFF);
    rd(5'h00, v); chk("R11 ctrl untouched", v, 32'h1234_5672 & 32'h7777_7777);
    rd(5'h08, v); chk("R11 ien untouched", v, 0);
    for (int a = 0; a < 32; a++) begin
      if (a != 0 && a != 8 && a != 16) begin
        rd(5'(a), v); chk("R11 unmapped read", v, 0);
      end
    end

    finish_run();
  end
endmodule